// File: doc/BRIEF.md
# Key-Protected Function-Select Write Gate

This block holds an 8-bit function-select register whose bits choose, per pad, between ordinary I/O and an alternate function. Writes to that register are filtered by a write-permission mask, and the mask itself can only be changed after software has unlocked the gate with an exact 32-bit key. Any other write to the lock location closes the gate again. This makes a stray store unlikely to reassign a sensitive pin.

Software reaches the block over a simple register bus. A request is one cycle with select, write flag, word address, data and byte strobes. Reads answer one cycle later with a valid pulse. The function-select value also drives the pad multiplexer directly through a dedicated output.

Top module: `keygate_top`

## Requirements
- R1: After reset, the lock location reads 1, the permission mask reads 0xFF, and the function-select register and its pad output are 0.
- R2: A write to offset 0x520 with all four byte strobes set and data exactly 0x0ACCE551 unlocks the gate; the lock location then reads 0.
- R3: Any other write to offset 0x520 locks the gate (lock reads 1). This includes any other data value, and the key value written with any strobe cleared.
- R4: A write to the permission mask at offset 0x524 stores bits [7:0] while the gate is unlocked. While the gate is locked, such a write leaves the mask unchanged.
- R5: A write to the function-select register at offset 0x420 changes only the bits whose permission-mask bit is 1. The register and the pad output show the new value in the cycle after the write.
- R6: A mask write on the bus cycle immediately after the unlocking write takes effect.
- R7: Reads return data one cycle after the request with a one-cycle valid pulse. The lock location reads 0 or 1. The mask and the function-select register read zero-extended. Any unmapped offset reads 0.
- R8: Mask and function-select writes take effect only when byte strobe 0 is set. A write to an unmapped offset changes no register, including the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Request valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte strobes for writes |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data |
| func_sel_o | output | 8 | Function-select bits to the pad multiplexer |

## Verification
A wrong lock state surfaces at the ports in one of two ways. A mask write that should have been refused shows a changed mask on the next read. A valid mask write that was dropped shows the old mask on the next read. A faulty mask shows one cycle after a function-select write, as wrong bits on `func_sel_o`. The bench therefore reads the mask back right after every gate transition and checks the pad output after each function-select write. A wrong lock state is exposed within two bus cycles of the access that went wrong.

// File: rtl/keygate_pkg.sv
package keygate_pkg;
  parameter int ADDR_W = 12;
  parameter int DATA_W = 32;
  parameter int FUNC_W = 8;
  localparam int STRB_W = DATA_W / 8;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0ACC_E551;
  localparam logic [ADDR_W-1:0] OFS_FUNC = 12'h420;
  localparam logic [ADDR_W-1:0] OFS_LOCK = 12'h520;
  localparam logic [ADDR_W-1:0] OFS_MASK = 12'h524;
endpackage

// File: rtl/keygate_rst_sync.sv
module keygate_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/keygate_lock_ctl.sv
module keygate_lock_ctl #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              full_word,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked_o
);
  logic locked_d, locked_q;

  always_comb begin
    locked_d = locked_q;
    if (wr_en) locked_d = !(full_word && (wdata == KEY));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked_q <= 1'b1;
    else        locked_q <= locked_d;
  end

  assign locked_o = locked_q;

  assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full_word && wdata == KEY) |=> !locked_o);
  assert_other_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(full_word && wdata == KEY)) |=> locked_o);
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(locked_o));
endmodule

// File: rtl/keygate_masked_reg.sv
module keygate_masked_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] bit_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] d, q_r;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign d[i] = (we && bit_en[i]) ? wdata[i] : q_r[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= RESET_VAL;
    else        q_r <= d;
  end

  assign q = q_r;

  assert_masked_bits_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (((q ^ $past(q)) & ~$past(bit_en)) == '0));
  assert_enabled_bits_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (((q ^ $past(wdata)) & $past(bit_en)) == '0));
  assert_no_write_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/keygate_top.sv
module keygate_top
  import keygate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [STRB_W-1:0] bus_wstrb,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [FUNC_W-1:0] func_sel_o
);
  logic              rst_i_n;
  logic [ADDR_W-3:0] word;
  logic              hit_func, hit_lock, hit_mask;
  logic              wr_lock, wr_mask, wr_func, rd_req;
  logic              locked;
  logic [FUNC_W-1:0] mask_q, func_q;
  logic [DATA_W-1:0] rd_mux, rd_data_q;
  logic              rd_valid_q;

  keygate_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign word     = bus_addr[ADDR_W-1:2];
  assign hit_func = (word == OFS_FUNC[ADDR_W-1:2]);
  assign hit_lock = (word == OFS_LOCK[ADDR_W-1:2]);
  assign hit_mask = (word == OFS_MASK[ADDR_W-1:2]);
  assign wr_lock  = bus_sel && bus_wr && hit_lock;
  assign wr_mask  = bus_sel && bus_wr && hit_mask && bus_wstrb[0];
  assign wr_func  = bus_sel && bus_wr && hit_func && bus_wstrb[0];
  assign rd_req   = bus_sel && !bus_wr;

  keygate_lock_ctl #(.DATA_W(DATA_W), .KEY(UNLOCK_KEY)) i_lock (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_lock),
    .full_word(&bus_wstrb), .wdata(bus_wdata), .locked_o(locked));

  keygate_masked_reg #(.W(FUNC_W), .RESET_VAL('1)) i_mask (
    .clk(clk), .rst_n(rst_i_n), .we(wr_mask && !locked),
    .bit_en('1), .wdata(bus_wdata[FUNC_W-1:0]), .q(mask_q));

  keygate_masked_reg #(.W(FUNC_W), .RESET_VAL('0)) i_func (
    .clk(clk), .rst_n(rst_i_n), .we(wr_func),
    .bit_en(mask_q), .wdata(bus_wdata[FUNC_W-1:0]), .q(func_q));

  always_comb begin
    rd_mux = '0;
    if (hit_lock)      rd_mux = {{(DATA_W-1){1'b0}}, locked};
    else if (hit_mask) rd_mux = {{(DATA_W-FUNC_W){1'b0}}, mask_q};
    else if (hit_func) rd_mux = {{(DATA_W-FUNC_W){1'b0}}, func_q};
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_req;
      if (rd_req) rd_data_q <= rd_mux;
    end
  end

  assign rd_valid   = rd_valid_q;
  assign rd_data    = rd_data_q;
  assign func_sel_o = func_q;

  assert_mask_frozen_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_sel && bus_wr && hit_mask && locked) |=> $stable(mask_q));
  assert_mask_open_write_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_mask && !locked) |=> (mask_q == $past(bus_wdata[FUNC_W-1:0])));
  assert_read_response_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_req |=> rd_valid);
  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_req |=> !rd_valid);
endmodule

// File: tb/test_keygate_top.sv
module test_keygate_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_wstrb;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [7:0]  func_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  keygate_top i_keygate_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .rd_valid(rd_valid), .rd_data(rd_data), .func_sel_o(func_sel_o));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0; bus_wstrb = '0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    bus_sel = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each read response with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 actual=%08h expected=no response", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_wstrb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check("R1 pad output", {24'h0, func_sel_o}, 32'h0);
    rd(12'h520, 32'h1,  "R1 lock");
    rd(12'h524, 32'hFF, "R1 mask");
    rd(12'h420, 32'h0,  "R1 func");
    // R5 full mask write
    wr(12'h420, 32'hFFFF_FFA5, 4'hF);
    check("R5 pad after full mask", {24'h0, func_sel_o}, 32'hA5);
    rd(12'h420, 32'hA5, "R5 func full mask");
    // R4 mask write while locked ignored
    wr(12'h524, 32'h0F, 4'hF);
    rd(12'h524, 32'hFF, "R4 mask locked");
    // R2 unlock
    wr(12'h520, 32'h0ACC_E551, 4'hF);
    rd(12'h520, 32'h0, "R2 lock open");
    // R6 unlock then mask write back-to-back
    wr(12'h520, 32'h0000_0000, 4'hF);
    wr(12'h520, 32'h0ACC_E551, 4'hF);
    wr(12'h524, 32'h0F, 4'hF);
    rd(12'h524, 32'h0F, "R6 mask right after unlock");
    // R5 partial mask
    wr(12'h420, 32'h5A, 4'hF);
    check("R5 pad masked", {24'h0, func_sel_o}, 32'hAA);
    rd(12'h420, 32'hAA, "R5 func masked");
    // R3 wrong key relocks
    wr(12'h520, 32'h0ACC_E550, 4'hF);
    rd(12'h520, 32'h1, "R3 lock wrong key");
    wr(12'h524, 32'h33, 4'hF);
    rd(12'h524, 32'h0F, "R3 mask after relock");
    // R3 key with partial strobes relocks
    wr(12'h520, 32'h0ACC_E551, 4'hF);
    wr(12'h520, 32'h0ACC_E551, 4'h7);
    rd(12'h520, 32'h1, "R3 lock partial strobe");
    // R8 strobe 0 needed; unmapped write harmless
    wr(12'h520, 32'h0ACC_E551, 4'hF);
    wr(12'h524, 32'h3C, 4'h2);
    rd(12'h524, 32'h0F, "R8 mask strobe0 clear");
    wr(12'h420, 32'h55, 4'hE);
    check("R8 pad strobe0 clear", {24'h0, func_sel_o}, 32'hAA);
    wr(12'h100, 32'hFFFF_FFFF, 4'hF);
    rd(12'h520, 32'h0, "R8 lock after unmapped write");
    rd(12'h420, 32'hAA, "R8 func after unmapped write");
    // R7 unmapped read
    rd(12'h100, 32'h0, "R7 unmapped");
    rd(12'h000, 32'h0, "R7 unmapped zero");
    // R4/R5 zero mask blocks all function-select writes
    wr(12'h524, 32'h00, 4'h1);
    wr(12'h420, 32'hFF, 4'hF);
    check("R5 pad zero mask", {24'h0, func_sel_o}, 32'hAA);
    rd(12'h524, 32'h00, "R4 mask written open");
    idle(3);
    check("R7 all responses seen", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule